// File: doc/BRIEF.md
# Stream-to-Memory Write Sink

This block is the memory end of a stream-to-memory write channel. A producer first hands it a write command. The command carries a byte start address, a byte count and a few fixed-encoding control fields. The producer then streams full-width data beats. The sink stores each beat in a local RAM that is addressed by line. The first beat goes to the line the command points at, and each further beat goes to the next line.

Once the beat flagged as last has been taken, the sink waits for a programmable number of cycles and then offers a completion status word. The status stays on offer until the consumer accepts it. Only then does the sink take another command. A command with a bad encoding or an out-of-range start line is still drained of its beats, but it writes nothing and reports a decode error. A combinational read port returns any RAM line, so the stored contents can be observed.

Top module: `s2m_write_sink`

## Requirements
- R1: After reset, `cmd_ready` is 1 and both `dat_ready` and `sts_valid` are 0.
- R2: Only one command encoding is legal: kind=1, align=0, end=1, realign=1, tag=0. For any other encoding, the status has decerr=1, okay=0, slverr=0, interr=0 and the command's tag in `sts_tag`, and no RAM line changes.
- R3: The start line is the byte address shifted right by 6. A start line greater than LINES-1 (15 by default) gives decerr=1 and okay=0 and writes nothing.
- R4: For a legal command, beat i is written to line (start+i) mod LINES. Line LINES-1 is followed by line 0. `rd_data` shows the line selected by `rd_line`.
- R5: A beat whose 64 keep bits are not all 1 is not written, but it still advances the line pointer. The status then has slverr=1 and okay=0.
- R6: The expected beat count is 1 + (len-1)/64. If the last beat arrives at any other count, the status has interr=1 and okay=0. A byte count of 0 is treated as illegal (decerr=1).
- R7: `sts_valid` rises exactly max(W,1) clock edges after the edge that accepts the last beat, where W is `reply_wait` sampled at that edge.
- R8: While `sts_valid` is 1 and `sts_ready` is 0, `sts_valid` and every status field stay unchanged. `sts_valid` drops on the edge after the handshake.
- R9: `cmd_ready` is 0 from the edge that accepts a command until the edge that completes its status handshake. `dat_ready` is 1 only between command acceptance and the last beat.
- R10: A clean transfer reports tag=0, okay=1, interr=0, slverr=0 and decerr=0. In every status, okay is 1 exactly when no error flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reply_wait | input | 8 | Status delay in cycles, sampled when the last beat is taken (0 or 1 = next cycle) |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken |
| cmd_addr | input | 40 | Start byte address |
| cmd_len | input | 23 | Byte count |
| cmd_kind | input | 1 | Transfer kind, must be 1 |
| cmd_align | input | 6 | Alignment field, must be 0 |
| cmd_end | input | 1 | End-of-frame flag, must be 1 |
| cmd_realign | input | 1 | Realign flag, must be 1 |
| cmd_tag | input | 4 | Command tag, must be 0; echoed in status |
| dat_valid | input | 1 | Data beat offered |
| dat_ready | output | 1 | Data beat can be taken |
| dat_data | input | 512 | Beat payload |
| dat_keep | input | 64 | Byte enables, all must be 1 |
| dat_last | input | 1 | Final beat of the command |
| sts_valid | output | 1 | Status offered |
| sts_ready | input | 1 | Status consumer has room |
| sts_tag | output | 4 | Tag of the completed command |
| sts_okay | output | 1 | Transfer clean |
| sts_interr | output | 1 | Beat count mismatch |
| sts_slverr | output | 1 | Partial keep seen |
| sts_decerr | output | 1 | Illegal encoding or start line |
| rd_line | input | 4 | Line to read back |
| rd_data | output | 512 | Contents of the selected line |

## Verification
The hardest situation to reach is a burst that runs past the end of the array and has to wrap. It matters most when it lands right after error commands that must have left every line untouched. The stimulus first fills all 16 lines with one legal full-array burst, so every line has a known value. It then runs a burst that starts at line 14 and sweeps the whole array through the read port. After that it issues commands with bad tags, bad alignment, a start line past the end and a zero count, and compares every line again. Timing of the status is measured by counting falling edges from the last beat, with both a short and a long delay. In the long-delay case the consumer also withholds ready, so the hold-off of new commands can be seen.

// File: rtl/s2m_pkg.sv
// Shared types for the stream-to-memory write sink.
// Assumes: nothing beyond IEEE 1800-2017 packed types.
package s2m_pkg;

    // Control sequence of one write: command, beats, delay, status.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DATA = 2'd1,
        ST_WAIT = 2'd2,
        ST_SEND = 2'd3
    } s2m_state_e;

    // Completion word returned to the producer side.
    typedef struct packed {
        logic [3:0] tag;
        logic       okay;
        logic       interr;
        logic       slverr;
        logic       decerr;
    } s2m_status_t;

    // The single command encoding that is accepted.
    localparam logic       LEGAL_KIND    = 1'b1;
    localparam logic [5:0] LEGAL_ALIGN   = 6'd0;
    localparam logic       LEGAL_END     = 1'b1;
    localparam logic       LEGAL_REALIGN = 1'b1;
    localparam logic [3:0] LEGAL_TAG     = 4'd0;

endpackage

// File: rtl/s2m_cmd_check.sv
// Decodes a write command: flags an illegal encoding, an out-of-range
// start line or a zero byte count, and derives the start line and the
// expected number of beats.
// Assumes: LINES is a power of two, so the low bits of the line index
// address the RAM directly.
module s2m_cmd_check
    import s2m_pkg::*;
#(
    parameter int ADDR_W  = 40,
    parameter int LEN_W   = 23,
    parameter int LINES   = 16,
    parameter int BYTE_SH = 6,
    localparam int LINE_W = $clog2(LINES)
) (
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [LEN_W-1:0]  cmd_len,
    input  logic              cmd_kind,
    input  logic [5:0]        cmd_align,
    input  logic              cmd_end,
    input  logic              cmd_realign,
    input  logic [3:0]        cmd_tag,
    output logic              bad_cmd,
    output logic [LINE_W-1:0] start_line,
    output logic [LEN_W-1:0]  expect_beats
);
    logic [ADDR_W-1:0] line_full;
    logic              enc_bad;
    logic              range_bad;

    // Decode legality, start line and beat count from the raw fields.
    always_comb begin
        line_full    = cmd_addr >> BYTE_SH;
        range_bad    = line_full > ADDR_W'(LINES - 1);
        enc_bad      = (cmd_kind != LEGAL_KIND) || (cmd_align != LEGAL_ALIGN) ||
                       (cmd_end != LEGAL_END) || (cmd_realign != LEGAL_REALIGN) ||
                       (cmd_tag != LEGAL_TAG);
        bad_cmd      = enc_bad || range_bad || (cmd_len == '0);
        start_line   = line_full[LINE_W-1:0];
        expect_beats = LEN_W'(1) + ((cmd_len - LEN_W'(1)) >> BYTE_SH);
    end
endmodule

// File: rtl/s2m_line_ram.sv
// Line-addressed storage: one synchronous write port, one
// combinational read port.
// Assumes: contents are not reset; a line holds one full beat.
module s2m_line_ram #(
    parameter int DATA_W  = 512,
    parameter int LINES   = 16,
    localparam int LINE_W = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [LINE_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [LINE_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [LINES];

    // Store one beat per enabled cycle.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Return the addressed line without delay.
    assign rdata = mem[raddr];
endmodule

// File: rtl/s2m_reply_timer.sv
// Down-counter that sets how long the status is held back.
// Assumes: the count is loaded on the edge that accepts the last beat
// and counts only while run is high; a load value of 0 or 1 expires
// at once.
module s2m_reply_timer #(
    parameter int WAIT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WAIT_W-1:0] load_val,
    input  logic              run,
    output logic              expire
);
    logic [WAIT_W-1:0] cnt;

    // Load on the last beat, then count down towards one.
    always_ff @(posedge clk) begin
        if (!rst_n)                    cnt <= '0;
        else if (load)                 cnt <= load_val;
        else if (run && cnt > WAIT_W'(1)) cnt <= cnt - WAIT_W'(1);
    end

    assign expire = (cnt <= WAIT_W'(1));
endmodule

// File: rtl/s2m_write_sink.sv
// Stream-to-memory write sink. Takes one command, stores its beats in
// consecutive RAM lines (wrapping at the end), then returns a status
// word after a programmable delay. Only one command is in flight.
// Assumes: beats only arrive after their command; an illegal command
// is drained of its beats without writing.
module s2m_write_sink
    import s2m_pkg::*;
#(
    parameter int DATA_W  = 512,
    parameter int ADDR_W  = 40,
    parameter int LEN_W   = 23,
    parameter int LINES   = 16,
    parameter int WAIT_W  = 8,
    localparam int KEEP_W  = DATA_W / 8,
    localparam int BYTE_SH = $clog2(KEEP_W),
    localparam int LINE_W  = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WAIT_W-1:0] reply_wait,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [LEN_W-1:0]  cmd_len,
    input  logic              cmd_kind,
    input  logic [5:0]        cmd_align,
    input  logic              cmd_end,
    input  logic              cmd_realign,
    input  logic [3:0]        cmd_tag,
    input  logic              dat_valid,
    output logic              dat_ready,
    input  logic [DATA_W-1:0] dat_data,
    input  logic [KEEP_W-1:0] dat_keep,
    input  logic              dat_last,
    output logic              sts_valid,
    input  logic              sts_ready,
    output logic [3:0]        sts_tag,
    output logic              sts_okay,
    output logic              sts_interr,
    output logic              sts_slverr,
    output logic              sts_decerr,
    input  logic [LINE_W-1:0] rd_line,
    output logic [DATA_W-1:0] rd_data
);
    s2m_state_e        state;
    logic [LINE_W-1:0] wr_ptr;
    logic [LEN_W-1:0]  beat_cnt;
    logic [LEN_W-1:0]  expect_r;
    logic [3:0]        tag_r;
    logic              bad_r, keep_err, cnt_err;

    logic              dec_bad;
    logic [LINE_W-1:0] dec_line;
    logic [LEN_W-1:0]  dec_beats;
    logic              cmd_fire, beat_fire, last_fire, full_keep, ram_we, expire;
    logic [LINE_W-1:0] next_ptr;
    s2m_status_t       sts;

    s2m_cmd_check #(
        .ADDR_W (ADDR_W),
        .LEN_W  (LEN_W),
        .LINES  (LINES),
        .BYTE_SH(BYTE_SH)
    ) u_check (
        .cmd_addr    (cmd_addr),
        .cmd_len     (cmd_len),
        .cmd_kind    (cmd_kind),
        .cmd_align   (cmd_align),
        .cmd_end     (cmd_end),
        .cmd_realign (cmd_realign),
        .cmd_tag     (cmd_tag),
        .bad_cmd     (dec_bad),
        .start_line  (dec_line),
        .expect_beats(dec_beats)
    );

    s2m_line_ram #(
        .DATA_W(DATA_W),
        .LINES (LINES)
    ) u_ram (
        .clk  (clk),
        .we   (ram_we),
        .waddr(wr_ptr),
        .wdata(dat_data),
        .raddr(rd_line),
        .rdata(rd_data)
    );

    s2m_reply_timer #(
        .WAIT_W(WAIT_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (last_fire),
        .load_val(reply_wait),
        .run     (state == ST_WAIT),
        .expire  (expire)
    );

    // Handshake qualifiers and next write line (wraps to 0).
    always_comb begin
        cmd_ready = (state == ST_IDLE);
        dat_ready = (state == ST_DATA);
        sts_valid = (state == ST_SEND);
        cmd_fire  = cmd_valid && cmd_ready;
        beat_fire = dat_valid && dat_ready;
        last_fire = beat_fire && dat_last;
        full_keep = &dat_keep;
        ram_we    = beat_fire && full_keep && !bad_r;
        next_ptr  = (wr_ptr == LINE_W'(LINES - 1)) ? '0 : wr_ptr + LINE_W'(1);
    end

    // Sequence one command through data, delay and status phases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            wr_ptr   <= '0;
            beat_cnt <= '0;
            expect_r <= '0;
            tag_r    <= '0;
            bad_r    <= 1'b0;
            keep_err <= 1'b0;
            cnt_err  <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: if (cmd_fire) begin
                    wr_ptr   <= dec_line;
                    bad_r    <= dec_bad;
                    tag_r    <= cmd_tag;
                    expect_r <= dec_beats;
                    beat_cnt <= '0;
                    keep_err <= 1'b0;
                    cnt_err  <= 1'b0;
                    state    <= ST_DATA;
                end
                ST_DATA: if (beat_fire) begin
                    wr_ptr   <= next_ptr;
                    beat_cnt <= beat_cnt + LEN_W'(1);
                    if (!full_keep) keep_err <= 1'b1;
                    if (dat_last) begin
                        cnt_err <= (beat_cnt + LEN_W'(1)) != expect_r;
                        state   <= ST_WAIT;
                    end
                end
                ST_WAIT: if (expire) state <= ST_SEND;
                ST_SEND: if (sts_ready) state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Build the status word; decode errors mask the other flags.
    always_comb begin
        sts.tag    = tag_r;
        sts.decerr = bad_r;
        sts.slverr = keep_err && !bad_r;
        sts.interr = cnt_err && !bad_r;
        sts.okay   = !(sts.decerr || sts.slverr || sts.interr);
        sts_tag    = sts.tag;
        sts_okay   = sts.okay;
        sts_interr = sts.interr;
        sts_slverr = sts.slverr;
        sts_decerr = sts.decerr;
    end
endmodule

// File: rtl/s2m_write_sink_sva.sv
// Protocol checks on the write sink's ports, bound to every instance.
// Assumes: checks are inactive while rst_n is low.
module s2m_write_sink_sva (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_ready,
    input logic       dat_valid,
    input logic       dat_ready,
    input logic       dat_last,
    input logic       sts_valid,
    input logic       sts_ready,
    input logic [3:0] sts_tag,
    input logic       sts_okay,
    input logic       sts_interr,
    input logic       sts_slverr,
    input logic       sts_decerr
);
    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> cmd_ready && !dat_ready && !sts_valid);

    assert_decerr_masks_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sts_valid && sts_decerr |-> !sts_slverr && !sts_interr);

    assert_no_early_status_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dat_valid && dat_ready && dat_last |=> !sts_valid);

    assert_status_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sts_valid && !sts_ready |=> sts_valid &&
        $stable({sts_tag, sts_okay, sts_interr, sts_slverr, sts_decerr}));

    assert_cmd_blocked_status_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sts_valid |-> !cmd_ready);

    assert_cmd_blocked_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
        dat_ready |-> !cmd_ready && !sts_valid);

    assert_okay_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sts_valid |-> sts_okay == !(sts_decerr || sts_slverr || sts_interr));
endmodule

bind s2m_write_sink s2m_write_sink_sva u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_ready (cmd_ready),
    .dat_valid (dat_valid),
    .dat_ready (dat_ready),
    .dat_last  (dat_last),
    .sts_valid (sts_valid),
    .sts_ready (sts_ready),
    .sts_tag   (sts_tag),
    .sts_okay  (sts_okay),
    .sts_interr(sts_interr),
    .sts_slverr(sts_slverr),
    .sts_decerr(sts_decerr)
);

// File: tb/s2m_write_sink_tb.sv
`timescale 1ns/1ps
// Directed bench for the write sink: one task per scenario.
module s2m_write_sink_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [7:0]   reply_wait = 8'd1;
    logic         cmd_valid = 1'b0;
    logic         cmd_ready;
    logic [39:0]  cmd_addr = '0;
    logic [22:0]  cmd_len = '0;
    logic         cmd_kind = 1'b0;
    logic [5:0]   cmd_align = '0;
    logic         cmd_end = 1'b0;
    logic         cmd_realign = 1'b0;
    logic [3:0]   cmd_tag = '0;
    logic         dat_valid = 1'b0;
    logic         dat_ready;
    logic [511:0] dat_data = '0;
    logic [63:0]  dat_keep = '0;
    logic         dat_last = 1'b0;
    logic         sts_valid;
    logic         sts_ready = 1'b0;
    logic [3:0]   sts_tag;
    logic         sts_okay, sts_interr, sts_slverr, sts_decerr;
    logic [3:0]   rd_line = '0;
    logic [511:0] rd_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [511:0] model [16];
    bit           known [16];

    always #2.5 clk = ~clk;

    s2m_write_sink u_dut (
        .clk(clk), .rst_n(rst_n), .reply_wait(reply_wait),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr),
        .cmd_len(cmd_len), .cmd_kind(cmd_kind), .cmd_align(cmd_align),
        .cmd_end(cmd_end), .cmd_realign(cmd_realign), .cmd_tag(cmd_tag),
        .dat_valid(dat_valid), .dat_ready(dat_ready), .dat_data(dat_data),
        .dat_keep(dat_keep), .dat_last(dat_last),
        .sts_valid(sts_valid), .sts_ready(sts_ready), .sts_tag(sts_tag),
        .sts_okay(sts_okay), .sts_interr(sts_interr), .sts_slverr(sts_slverr),
        .sts_decerr(sts_decerr), .rd_line(rd_line), .rd_data(rd_data)
    );

    function automatic logic [511:0] pat(input int seed);
        logic [511:0] d;
        for (int k = 0; k < 16; k++) d[k*32 +: 32] = 32'(seed) * 32'h0100_0193 + 32'(k);
        return d;
    endfunction

    task automatic check_eq(input string req, input string what,
                            input logic [511:0] act, input logic [511:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Compare every line whose content the bench knows.
    task automatic check_mem(input string req);
        for (int l = 0; l < 16; l++) begin
            if (known[l]) begin
                rd_line = 4'(l);
                #0.5;
                check_eq(req, $sformatf("line %0d", l), rd_data, model[l]);
            end
        end
    endtask

    // One full transfer: command, beats, status with optional hold-off.
    // st = {tag, okay, interr, slverr, decerr}; lat = negedges to sts_valid.
    task automatic run_xfer(input logic [39:0] addr, input logic [22:0] len,
                            input logic kind, input logic [5:0] align,
                            input logic endf, input logic realign, input logic [3:0] tag,
                            input int nbeats, input int bad_beat, input int seed,
                            input bit writes, input logic [7:0] w, input int hold,
                            output logic [7:0] st, output int lat);
        reply_wait = w;
        cmd_addr = addr; cmd_len = len; cmd_kind = kind; cmd_align = align;
        cmd_end = endf; cmd_realign = realign; cmd_tag = tag;
        cmd_valid = 1'b1;
        while (!cmd_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        for (int i = 0; i < nbeats; i++) begin
            dat_valid = 1'b1;
            dat_data  = pat(seed + i);
            dat_keep  = (i == bad_beat) ? 64'hFFFF_FFFF_FFFF_FFFE : '1;
            dat_last  = (i == nbeats - 1);
            while (!dat_ready) @(negedge clk);
            @(posedge clk);
            @(negedge clk);
            if (writes && i != bad_beat) begin
                model[(int'(addr[9:6]) + i) % 16] = pat(seed + i);
                known[(int'(addr[9:6]) + i) % 16] = 1'b1;
            end
        end
        dat_valid = 1'b0;
        dat_last  = 1'b0;
        lat = 0;
        while (!sts_valid && lat < 300) begin
            @(negedge clk);
            lat++;
        end
        st = {sts_tag, sts_okay, sts_interr, sts_slverr, sts_decerr};
        for (int h = 0; h < hold; h++) begin
            @(negedge clk);
            check_eq("R8", "held status", 512'({sts_valid, sts_tag, sts_okay, sts_interr,
                     sts_slverr, sts_decerr}), 512'({1'b1, st}));
            check_eq("R9", "cmd_ready during pending status", 512'(cmd_ready), 512'(0));
        end
        sts_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        sts_ready = 1'b0;
        check_eq("R8", "sts_valid after handshake", 512'(sts_valid), 512'(0));
        check_eq("R9", "cmd_ready after handshake", 512'(cmd_ready), 512'(1));
    endtask

    task automatic test_reset();
        check_eq("R1", "cmd_ready", 512'(cmd_ready), 512'(1));
        check_eq("R1", "dat_ready", 512'(dat_ready), 512'(0));
        check_eq("R1", "sts_valid", 512'(sts_valid), 512'(0));
    endtask

    task automatic test_fill();
        logic [7:0] st; int lat;
        run_xfer(40'd0, 23'd1024, 1, 0, 1, 1, 0, 16, -1, 100, 1, 8'd1, 0, st, lat);
        check_eq("R10", "clean status", 512'(st), 512'(8'h08));
        check_eq("R7", "latency W=1", 512'(lat), 512'(1));
        check_mem("R4");
    endtask

    task automatic test_latency();
        logic [7:0] st; int lat;
        run_xfer(40'd128, 23'd150, 1, 0, 1, 1, 0, 3, -1, 200, 1, 8'd5, 3, st, lat);
        check_eq("R10", "clean status", 512'(st), 512'(8'h08));
        check_eq("R7", "latency W=5", 512'(lat), 512'(5));
        check_mem("R4");
        run_xfer(40'd192, 23'd64, 1, 0, 1, 1, 0, 1, -1, 210, 1, 8'd0, 0, st, lat);
        check_eq("R7", "latency W=0", 512'(lat), 512'(1));
    endtask

    task automatic test_wrap();
        logic [7:0] st; int lat;
        run_xfer(40'd896, 23'd256, 1, 0, 1, 1, 0, 4, -1, 300, 1, 8'd2, 0, st, lat);
        check_eq("R10", "clean status", 512'(st), 512'(8'h08));
        check_eq("R7", "latency W=2", 512'(lat), 512'(2));
        check_mem("R4");
    endtask

    task automatic test_bad_encoding();
        logic [7:0] st; int lat;
        run_xfer(40'd64, 23'd128, 1, 0, 1, 1, 4'h3, 2, -1, 400, 0, 8'd1, 0, st, lat);
        check_eq("R2", "bad tag status", 512'(st), 512'(8'h31));
        run_xfer(40'd64, 23'd64, 1, 6'd1, 1, 1, 0, 1, -1, 410, 0, 8'd1, 0, st, lat);
        check_eq("R2", "bad align status", 512'(st), 512'(8'h01));
        run_xfer(40'd64, 23'd64, 0, 0, 1, 0, 0, 1, -1, 420, 0, 8'd1, 0, st, lat);
        check_eq("R2", "bad kind status", 512'(st), 512'(8'h01));
        check_mem("R2");
    endtask

    task automatic test_out_of_range();
        logic [7:0] st; int lat;
        run_xfer(40'd1024, 23'd64, 1, 0, 1, 1, 0, 1, -1, 500, 0, 8'd1, 0, st, lat);
        check_eq("R3", "line 16 status", 512'(st), 512'(8'h01));
        run_xfer(40'h80_0000_0000, 23'd64, 1, 0, 1, 1, 0, 1, -1, 510, 0, 8'd1, 0, st, lat);
        check_eq("R3", "high address status", 512'(st), 512'(8'h01));
        check_mem("R3");
    endtask

    task automatic test_keep();
        logic [7:0] st; int lat;
        run_xfer(40'd320, 23'd192, 1, 0, 1, 1, 0, 3, 1, 600, 1, 8'd1, 0, st, lat);
        check_eq("R5", "partial keep status", 512'(st), 512'(8'h02));
        check_mem("R5");
    endtask

    task automatic test_count();
        logic [7:0] st; int lat;
        run_xfer(40'd512, 23'd192, 1, 0, 1, 1, 0, 2, -1, 700, 1, 8'd1, 0, st, lat);
        check_eq("R6", "short burst status", 512'(st), 512'(8'h04));
        run_xfer(40'd512, 23'd0, 1, 0, 1, 1, 0, 1, -1, 710, 0, 8'd1, 0, st, lat);
        check_eq("R6", "zero length status", 512'(st), 512'(8'h01));
        check_mem("R6");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int l = 0; l < 16; l++) known[l] = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_fill();
        test_latency();
        test_wrap();
        test_bad_encoding();
        test_out_of_range();
        test_keep();
        test_count();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule